// File: doc/BRIEF.md
# Poison-Aware Speculative Retirement Stage

This block owns the head of a small reorder buffer and retires its entries strictly in program order, at most one per cycle. Rename allocates entries at the tail, with an opcode tag and the physical register that the instruction's destination displaced. Execution later marks each entry either as completed or as poisoned, meaning it depends on an outstanding long-latency miss. A poisoned mark also records the source value that does not depend on the miss. When the head entry is resolved, the block returns the displaced physical register to the free list in the same cycle.

A completed entry is then simply dropped. A poisoned entry moves into a program-ordered slice FIFO together with its captured source value, so the slice does not depend on the rest of the program. A valid/ready slice-in port drains that FIFO once the miss returns, so that the instructions can be renamed again and re-issued. A full slice FIFO stalls a poisoned head. A flush returns both the reorder buffer and the slice FIFO to the empty checkpoint state.

Top module: `spec_retire`

## Requirements
- R1: Only the oldest reorder-buffer entry is considered for retirement, entries leave in allocation order, and at most one retires per cycle. An empty buffer retires nothing.
- R2: A head entry that has not been marked since allocation (pending) does not retire, and `freeValid` stays low.
- R3: In the cycle an entry retires, `freeValid` is high and `freePreg` carries the displaced register given at allocation for that entry.
- R4: A head marked completed (`markPoison`=0) retires without adding anything to the slice FIFO.
- R5: A head marked poisoned (`markPoison`=1) retires into the slice FIFO. The FIFO keeps these entries in retirement order, each with its opcode tag and the source value captured by its most recent mark.
- R6: While the slice FIFO holds `SLICE_DEPTH` entries, a poisoned head does not retire, even in a cycle where an entry is being drained.
- R7: `sliceValid` is high whenever the slice FIFO is not empty, and `sliceOp`/`sliceVal` show its oldest entry. An entry is removed on a cycle with `sliceValid` and `sliceReady` both high, and a push and a removal may happen in the same cycle.
- R8: A cycle with `flush` high empties both the reorder buffer and the slice FIFO. In that cycle `freeValid`, `sliceValid` and `allocReady` are low, and the next allocation receives index 0.
- R9: `allocReady` is low exactly when the buffer holds `ROB_DEPTH` entries or `flush` is high. Accepted allocations receive indices 0, 1, 2 … that wrap modulo `ROB_DEPTH`, shown on `allocIdx`.
- R10: A mark updates the entry's state and captured value at the next clock edge. A mark on the head therefore affects retirement from the following cycle on, and a later mark overwrites an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Return to empty checkpoint state |
| allocValid | input | 1 | Rename offers a new entry |
| allocReady | output | 1 | Entry accepted this cycle if allocValid |
| allocOp | input | OP_W | Opcode tag of the new entry |
| allocPrev | input | PREG_W | Physical register displaced by the new entry |
| allocIdx | output | log2(ROB_DEPTH) | Index the new entry receives |
| markValid | input | 1 | Execution resolves an entry |
| markIdx | input | log2(ROB_DEPTH) | Index of the resolved entry |
| markPoison | input | 1 | 1 = poisoned, 0 = completed |
| markVal | input | VAL_W | Captured miss-independent source value |
| freeValid | output | 1 | A register is released this cycle (entry retires) |
| freePreg | output | PREG_W | Released physical register |
| sliceValid | output | 1 | Slice FIFO holds an entry |
| sliceReady | input | 1 | Slice-in side accepts the oldest entry |
| sliceOp | output | OP_W | Opcode tag of oldest slice entry |
| sliceVal | output | VAL_W | Captured source value of oldest slice entry |

## Verification
In the same cycle, a poisoned head can be pushed into the slice FIFO while the slice-in side drains the FIFO's oldest entry. Allocation at the tail can also coincide with retirement at the head. The bench provokes both with long random runs that allocate often, poison most marks and toggle `sliceReady`. Phases with `sliceReady` held low fill the FIFO to its limit and then release it, so pushes against a full FIFO and simultaneous push/drain cycles both occur. A behavioural queue model predicts every output in every cycle. Its occupancies and contents are judged against the RTL's outputs, so a push lost or doubled during a drain shows up as a wrong `sliceOp`/`sliceVal` sequence.

// File: rtl/spec_retire_pkg.sv
package spec_retire_pkg;

  typedef enum logic [1:0] {
    ST_PEND   = 2'b00,
    ST_DONE   = 2'b01,
    ST_POISON = 2'b10
  } robStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic alloc;
    logic mark;
    logic retire;
    logic toSlice;
    logic slicePop;
  } strobe_t;

endpackage

// File: rtl/slice_fifo.sv
module slice_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full,
  output logic [AW:0]      count
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] rdPtr, wrPtr;

  assign count   = wrPtr - rdPtr;
  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign popData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (clear) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wrPtr[AW-1:0]] <= pushData;
  end
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import spec_retire_pkg::*;
(
  input  logic     flush,
  input  logic     allocValid,
  input  logic     markValid,
  input  logic     sliceReady,
  input  logic     robEmpty,
  input  logic     robFull,
  input  robStat_t headStat,
  input  logic     sliceEmpty,
  input  logic     sliceFull,
  output strobe_t  str,
  output logic     allocReady,
  output logic     freeValid,
  output logic     sliceValid
);
  logic headResolved, canRetire;

  always_comb begin
    headResolved = !robEmpty && (headStat != ST_PEND);
    canRetire    = headResolved && ((headStat == ST_DONE) || !sliceFull);

    str          = '0;
    str.clear    = flush;
    str.alloc    = !flush && allocValid && !robFull;
    str.mark     = !flush && markValid;
    str.retire   = !flush && canRetire;
    str.toSlice  = str.retire && (headStat == ST_POISON);
    str.slicePop = !flush && !sliceEmpty && sliceReady;

    allocReady   = !flush && !robFull;
    freeValid    = str.retire;
    sliceValid   = !flush && !sliceEmpty;
  end
endmodule

// File: rtl/retire_dp.sv
module retire_dp
  import spec_retire_pkg::*;
#(
  parameter int ROB_DEPTH   = 8,
  parameter int SLICE_DEPTH = 4,
  parameter int PREG_W      = 6,
  parameter int OP_W        = 8,
  parameter int VAL_W       = 16,
  localparam int ROB_AW     = $clog2(ROB_DEPTH),
  localparam int SL_AW      = $clog2(SLICE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [OP_W-1:0]   allocOp,
  input  logic [PREG_W-1:0] allocPrev,
  input  logic [ROB_AW-1:0] markIdx,
  input  logic              markPoison,
  input  logic [VAL_W-1:0]  markVal,
  output logic [ROB_AW-1:0] allocIdx,
  output logic              robEmpty,
  output logic              robFull,
  output robStat_t          headStat,
  output logic [PREG_W-1:0] freePreg,
  output logic              sliceEmpty,
  output logic              sliceFull,
  output logic [OP_W-1:0]   sliceOp,
  output logic [VAL_W-1:0]  sliceVal,
  output logic [ROB_AW:0]   robCnt,
  output logic [SL_AW:0]    sliceCnt
);
  localparam int SL_W = OP_W + VAL_W;
  localparam logic [ROB_AW:0] ROB_FULL_CNT = (ROB_AW+1)'(ROB_DEPTH);

  logic [ROB_AW:0]   headPtr, tailPtr;
  logic [OP_W-1:0]   robOp   [ROB_DEPTH];
  logic [PREG_W-1:0] robPrev [ROB_DEPTH];
  logic [VAL_W-1:0]  robVal  [ROB_DEPTH];
  robStat_t          robSt   [ROB_DEPTH];

  logic [ROB_AW-1:0] headIdx;
  logic [SL_W-1:0]   slicePush, sliceHead;

  assign headIdx  = headPtr[ROB_AW-1:0];
  assign allocIdx = tailPtr[ROB_AW-1:0];
  assign robCnt   = tailPtr - headPtr;
  assign robEmpty = (robCnt == '0);
  assign robFull  = (robCnt == ROB_FULL_CNT);
  assign headStat = robSt[headIdx];
  assign freePreg = robPrev[headIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (str.clear) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (str.alloc)  tailPtr <= tailPtr + 1'b1;
      if (str.retire) headPtr <= headPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROB_DEPTH; i++) robSt[i] <= ST_PEND;
    end else begin
      if (str.alloc) robSt[allocIdx] <= ST_PEND;
      if (str.mark)  robSt[markIdx]  <= markPoison ? ST_POISON : ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (str.alloc) begin
      robOp[allocIdx]   <= allocOp;
      robPrev[allocIdx] <= allocPrev;
    end
    if (str.mark) robVal[markIdx] <= markVal;
  end

  assign slicePush = {robOp[headIdx], robVal[headIdx]};

  slice_fifo #(.DEPTH(SLICE_DEPTH), .WIDTH(SL_W)) u_slice (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (str.clear),
    .push     (str.toSlice),
    .pushData (slicePush),
    .pop      (str.slicePop),
    .popData  (sliceHead),
    .empty    (sliceEmpty),
    .full     (sliceFull),
    .count    (sliceCnt)
  );

  assign sliceOp  = sliceHead[SL_W-1:VAL_W];
  assign sliceVal = sliceHead[VAL_W-1:0];
endmodule

// File: rtl/spec_retire.sv
module spec_retire
  import spec_retire_pkg::*;
#(
  parameter int ROB_DEPTH   = 8,
  parameter int SLICE_DEPTH = 4,
  parameter int PREG_W      = 6,
  parameter int OP_W        = 8,
  parameter int VAL_W       = 16,
  localparam int ROB_AW     = $clog2(ROB_DEPTH),
  localparam int SL_AW      = $clog2(SLICE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              allocValid,
  output logic              allocReady,
  input  logic [OP_W-1:0]   allocOp,
  input  logic [PREG_W-1:0] allocPrev,
  output logic [ROB_AW-1:0] allocIdx,
  input  logic              markValid,
  input  logic [ROB_AW-1:0] markIdx,
  input  logic              markPoison,
  input  logic [VAL_W-1:0]  markVal,
  output logic              freeValid,
  output logic [PREG_W-1:0] freePreg,
  output logic              sliceValid,
  input  logic              sliceReady,
  output logic [OP_W-1:0]   sliceOp,
  output logic [VAL_W-1:0]  sliceVal
);
  strobe_t  str;
  robStat_t headStat;
  logic robEmpty, robFull, sliceEmpty, sliceFull;
  logic [ROB_AW:0] robCnt;
  logic [SL_AW:0]  sliceCnt;

  retire_ctrl u_ctrl (
    .flush      (flush),
    .allocValid (allocValid),
    .markValid  (markValid),
    .sliceReady (sliceReady),
    .robEmpty   (robEmpty),
    .robFull    (robFull),
    .headStat   (headStat),
    .sliceEmpty (sliceEmpty),
    .sliceFull  (sliceFull),
    .str        (str),
    .allocReady (allocReady),
    .freeValid  (freeValid),
    .sliceValid (sliceValid)
  );

  retire_dp #(
    .ROB_DEPTH(ROB_DEPTH), .SLICE_DEPTH(SLICE_DEPTH),
    .PREG_W(PREG_W), .OP_W(OP_W), .VAL_W(VAL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .allocOp    (allocOp),
    .allocPrev  (allocPrev),
    .markIdx    (markIdx),
    .markPoison (markPoison),
    .markVal    (markVal),
    .allocIdx   (allocIdx),
    .robEmpty   (robEmpty),
    .robFull    (robFull),
    .headStat   (headStat),
    .freePreg   (freePreg),
    .sliceEmpty (sliceEmpty),
    .sliceFull  (sliceFull),
    .sliceOp    (sliceOp),
    .sliceVal   (sliceVal),
    .robCnt     (robCnt),
    .sliceCnt   (sliceCnt)
  );
endmodule

// File: rtl/spec_retire_chk.sv
module spec_retire_chk #(
  parameter int ROB_DEPTH   = 8,
  parameter int SLICE_DEPTH = 4,
  localparam int ROB_AW     = $clog2(ROB_DEPTH),
  localparam int SL_AW      = $clog2(SLICE_DEPTH)
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic            allocValid,
  input logic            allocReady,
  input logic            freeValid,
  input logic            sliceValid,
  input logic            sliceReady,
  input logic [ROB_AW:0] robCnt,
  input logic [SL_AW:0]  sliceCnt
);
  localparam logic [ROB_AW:0] ROB_ONE  = (ROB_AW+1)'(1);
  localparam logic [SL_AW:0]  SL_ONE   = (SL_AW+1)'(1);
  localparam logic [SL_AW:0]  SL_LIMIT = (SL_AW+1)'(SLICE_DEPTH);

  // R1: one retirement without allocation shrinks the buffer by exactly one
  a_r1_single_retire: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && freeValid && !(allocValid && allocReady)) |=> (robCnt == $past(robCnt) - ROB_ONE));

  // R1: nothing retires from an empty buffer
  a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    (robCnt == '0) |-> !freeValid);

  // R6: slice occupancy never exceeds its depth
  a_r6_slice_bound: assert property (@(posedge clk) disable iff (!rstN)
    sliceCnt <= SL_LIMIT);

  // R7: a drain without a retirement shrinks the slice FIFO by one
  a_r7_slice_drain: assert property (@(posedge clk) disable iff (!rstN)
    (sliceValid && sliceReady && !freeValid) |=> (sliceCnt == $past(sliceCnt) - SL_ONE));

  // R8: flush empties both structures
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (robCnt == '0 && sliceCnt == '0));

  // R9: allocation is refused while the buffer is full
  a_r9_full_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (robCnt == (ROB_AW+1)'(ROB_DEPTH)) |-> !allocReady);
endmodule

bind spec_retire spec_retire_chk #(.ROB_DEPTH(ROB_DEPTH), .SLICE_DEPTH(SLICE_DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .allocValid (allocValid),
  .allocReady (allocReady),
  .freeValid  (freeValid),
  .sliceValid (sliceValid),
  .sliceReady (sliceReady),
  .robCnt     (robCnt),
  .sliceCnt   (sliceCnt)
);

// File: tb/spec_retire_bench.sv
module spec_retire_bench;
  localparam int ROB_DEPTH   = 8;
  localparam int SLICE_DEPTH = 4;
  localparam int PREG_W = 6;
  localparam int OP_W   = 8;
  localparam int VAL_W  = 16;
  localparam int ROB_AW = $clog2(ROB_DEPTH);
  localparam int ST_PEND = 0, ST_DONE = 1, ST_POIS = 2;

  logic clk = 0, rstN = 0, flush = 0;
  logic allocValid = 0, markValid = 0, markPoison = 0, sliceReady = 0;
  logic allocReady, freeValid, sliceValid;
  logic [OP_W-1:0]   allocOp = '0, sliceOp;
  logic [PREG_W-1:0] allocPrev = '0, freePreg;
  logic [ROB_AW-1:0] allocIdx, markIdx = '0;
  logic [VAL_W-1:0]  markVal = '0, sliceVal;

  always #10 clk = ~clk;

  spec_retire #(.ROB_DEPTH(ROB_DEPTH), .SLICE_DEPTH(SLICE_DEPTH),
                .PREG_W(PREG_W), .OP_W(OP_W), .VAL_W(VAL_W)) u_spec_retire (
    .clk(clk), .rstN(rstN), .flush(flush),
    .allocValid(allocValid), .allocReady(allocReady), .allocOp(allocOp),
    .allocPrev(allocPrev), .allocIdx(allocIdx),
    .markValid(markValid), .markIdx(markIdx), .markPoison(markPoison), .markVal(markVal),
    .freeValid(freeValid), .freePreg(freePreg),
    .sliceValid(sliceValid), .sliceReady(sliceReady), .sliceOp(sliceOp), .sliceVal(sliceVal)
  );

  typedef struct { int idx; int op; int prev; int val; int st; } ent_t;
  ent_t robQ[$];
  ent_t sliceQ[$];
  int tailIdx = 0;
  int nChecks = 0, nFails = 0;
  bit flushedLast = 0, markedHeadLast = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit roll(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic step(input int pA, input int pM, input int pP, input int pR, input int pF);
    bit expAR, expFree, expSV;
    string tag;
    ent_t h;
    @(negedge clk);
    flush      = roll(pF);
    allocValid = roll(pA);
    allocOp    = OP_W'($urandom);
    allocPrev  = PREG_W'($urandom);
    markValid  = 0;
    if (robQ.size() > 0 && roll(pM)) begin
      int k = $urandom_range(robQ.size() - 1);
      markValid  = 1;
      markIdx    = ROB_AW'(robQ[k].idx);
      markPoison = roll(pP);
      markVal    = VAL_W'($urandom);
    end
    sliceReady = roll(pR);
    #1;
    // expected outputs from the model
    expAR = !flush && (robQ.size() < ROB_DEPTH);
    expFree = 0;
    if (!flush && robQ.size() > 0) begin
      h = robQ[0];
      expFree = (h.st == ST_DONE) || (h.st == ST_POIS && sliceQ.size() < SLICE_DEPTH);
    end
    expSV = !flush && (sliceQ.size() > 0);

    chk(allocReady == expAR, "R9", "allocReady", int'(allocReady), int'(expAR));
    chk(int'(allocIdx) == tailIdx, flushedLast ? "R8" : "R9", "allocIdx", int'(allocIdx), tailIdx);

    if (flush) tag = "R8";
    else if (robQ.size() == 0) tag = "R1";
    else if (markedHeadLast) tag = "R10";
    else if (robQ[0].st == ST_PEND) tag = "R2";
    else if (robQ[0].st == ST_POIS && sliceQ.size() >= SLICE_DEPTH) tag = "R6";
    else if (robQ[0].st == ST_DONE) tag = "R4";
    else tag = "R5";
    chk(freeValid == expFree, tag, "freeValid", int'(freeValid), int'(expFree));
    if (expFree && freeValid)
      chk(int'(freePreg) == robQ[0].prev, "R3", "freePreg", int'(freePreg), robQ[0].prev);

    chk(sliceValid == expSV, flush ? "R8" : "R7", "sliceValid", int'(sliceValid), int'(expSV));
    if (expSV && sliceValid) begin
      chk(int'(sliceOp) == sliceQ[0].op, "R5", "sliceOp", int'(sliceOp), sliceQ[0].op);
      chk(int'(sliceVal) == sliceQ[0].val, "R5", "sliceVal", int'(sliceVal), sliceQ[0].val);
    end

    // model update for the coming edge
    markedHeadLast = 0;
    flushedLast = flush;
    if (flush) begin
      robQ.delete();
      sliceQ.delete();
      tailIdx = 0;
    end else begin
      if (expSV && sliceReady) void'(sliceQ.pop_front());
      if (expFree) begin
        h = robQ.pop_front();
        if (h.st == ST_POIS) sliceQ.push_back(h);
      end
      if (markValid) begin
        foreach (robQ[i]) if (robQ[i].idx == int'(markIdx)) begin
          robQ[i].st  = markPoison ? ST_POIS : ST_DONE;
          robQ[i].val = int'(markVal);
          if (i == 0) markedHeadLast = 1;
        end
      end
      if (allocValid && expAR) begin
        ent_t n;
        n.idx = tailIdx; n.op = int'(allocOp); n.prev = int'(allocPrev);
        n.val = 0; n.st = ST_PEND;
        robQ.push_back(n);
        tailIdx = (tailIdx + 1) % ROB_DEPTH;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk(allocReady == 1'b1, "R9", "reset allocReady", int'(allocReady), 1);
    chk(freeValid == 1'b0, "R1", "reset freeValid", int'(freeValid), 0);
    chk(sliceValid == 1'b0, "R7", "reset sliceValid", int'(sliceValid), 0);
    chk(allocIdx == '0, "R8", "reset allocIdx", int'(allocIdx), 0);
    rstN = 1;
    // fill, mark slowly: pending-head stalls and full buffer
    repeat (40)  step(90, 10, 50, 50, 0);
    // mixed traffic with rare flushes
    repeat (400) step(60, 40, 50, 50, 2);
    // slice-in blocked: fill slice FIFO and stall poisoned heads
    repeat (200) step(70, 60, 90, 0, 0);
    // release: push and drain together
    repeat (200) step(70, 60, 90, 100, 0);
    // heavy marks with overwrites, mostly completed
    repeat (200) step(50, 90, 20, 60, 1);
    // alternating ready
    repeat (300) step(80, 50, 70, 30, 1);
    // a few flushes in a row
    repeat (10)  step(50, 50, 50, 50, 60);
    repeat (100) step(60, 50, 50, 50, 0);
    @(negedge clk);
    allocValid = 0; markValid = 0; flush = 0;
    summary();
    $finish;
  end
endmodule